// File: doc/BRIEF.md
# Per-Master Bus Error Syndrome Capture

This block sits beside the slave port of a bus bridge and records the errors that port reports. It keeps one syndrome group for each of four requesting masters. Each group holds a three-bit error type code, a flag that tells whether the failing transfer was a read, and a capture lock. Error events arrive one per cycle. Each event carries the master ID, an error class (parity, master abort or target abort), a direction flag and a lock request that is sampled together with the error.

When a master's lock is clear, every new error for that master overwrites its group. If the lock request is high when the error is recorded, the lock is also set. After that the group is frozen against later errors until software clears the lock. Software sees all four groups in a single 32-bit word. It clears any bit by writing 1 to it; writing 0 leaves the bit as it is. The read data is combinational from the stored state.

Top module: `err_syndrome_capture`

## Requirements
- R1: A synchronous active-high reset sets every group to zero, so the read word is 32'h0000_0000.
- R2: A parity error (class code 2'b01) loads the master's type field, bits [2:0] of its byte, with 3'b001.
- R3: A master abort (class 2'b10) or a target abort (class 2'b11) loads the type field with 3'b101.
- R4: Bit 3 of the master's byte records the direction of the failing transfer: 1 means read, 0 means write.
- R5: An error recorded while the lock request is high sets the master's lock bit, bit 4 of its byte.
- R6: An error recorded while the lock request is low leaves the lock bit at 0. A later error for the same master overwrites the type and direction fields.
- R7: While a master's lock bit is 1, a new error for that master leaves all three of its fields unchanged.
- R8: A software write clears each field bit written with 1 and leaves each bit written with 0 unchanged. The lock bit can be cleared only in this way. Once it is cleared, errors are captured again.
- R9: When a capture and a software clear hit the same unlocked master in the same cycle, the captured values are stored and the clear has no effect on that master.
- R10: An event with the valid strobe low, or with class code 2'b00, changes no group.
- R11: Master 0 occupies bits [31:24], master 1 bits [23:16], master 2 bits [15:8] and master 3 bits [7:0]. Bits [7:5] of each byte always read 0, and writes to them have no effect.
- R12: An error for one master changes no other master's group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event strobe |
| ev_master | input | 2 | ID of the master that saw the error |
| ev_class | input | 2 | Error class: 01 parity, 10 master abort, 11 target abort |
| ev_read | input | 1 | 1 if the failing transfer was a read |
| ev_lock_req | input | 1 | Lock request sampled with the error |
| sw_wr | input | 1 | Software write strobe (write-1-to-clear) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Packed syndrome word |

## Verification
Two functions can fall in the same cycle: a hardware capture and a software write-1-to-clear. The bench provokes this by raising the event strobe and the write strobe in the same cycle. Sometimes the target master is unlocked; sometimes it is locked while the write also clears its lock. Every other master is cleared in that same cycle. The bench judges the result by reading the word one cycle later. An unlocked master must show the captured values untouched by the clear. A locked master must show only the clear. The other bytes must read zero.

// File: rtl/esc_pkg.sv
package esc_pkg;
   localparam int TYPE_W = 3;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'b00,
      CLS_PARITY = 2'b01,
      CLS_MABORT = 2'b10,
      CLS_TABORT = 2'b11
   } err_class_e;

   localparam logic [TYPE_W-1:0] CODE_PARITY = 3'b001;
   localparam logic [TYPE_W-1:0] CODE_ABORT  = 3'b101;

   typedef struct packed {
      logic              lock;
      logic              rd;
      logic [TYPE_W-1:0] etype;
   } syn_t;

   localparam int SYN_W = $bits(syn_t);
endpackage

// File: rtl/esc_evt_decode.sv
module esc_evt_decode
   import esc_pkg::*;
#(
   parameter int NUM_MASTERS = 4,
   parameter int ID_W        = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ev_valid,
   input  logic [ID_W-1:0]          ev_master,
   input  logic [1:0]               ev_class,
   output logic [NUM_MASTERS-1:0]   hit,
   output logic [TYPE_W-1:0]        code
);
   logic is_err;

   always_comb begin
      unique case (err_class_e'(ev_class))
         CLS_PARITY: code = CODE_PARITY;
         CLS_MABORT,
         CLS_TABORT: code = CODE_ABORT;
         default:    code = '0;
      endcase
   end

   assign is_err = ev_valid && (err_class_e'(ev_class) != CLS_NONE);

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_sel
      assign hit[m] = is_err && (ev_master == ID_W'(m));
   end

   // R12: an event selects at most one group
   a_r12_single_hit: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));
   // R10: a strobe-less or class-less event selects nothing
   a_r10_no_hit: assert property (@(posedge clk) disable iff (rst)
      (!ev_valid || ev_class == 2'b00) |-> (hit == '0));
endmodule

// File: rtl/esc_syn_group.sv
module esc_syn_group
   import esc_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              hit,
   input  logic [TYPE_W-1:0] code,
   input  logic              rd_in,
   input  logic              lock_req,
   input  syn_t              clr,
   output syn_t              q
);
   logic cap;

   assign cap = hit && !q.lock;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (cap) begin
         q.lock  <= lock_req;
         q.rd    <= rd_in;
         q.etype <= code;
      end else begin
         q <= q & ~clr;
      end
   end

   // R9: a capture stores the event even when a clear arrives with it
   a_r9_capture_wins: assert property (@(posedge clk) disable iff (rst)
      (hit && !q.lock) |=> (q.etype == $past(code) && q.rd == $past(rd_in)
                            && q.lock == $past(lock_req)));
   // R5: lock request at capture sets the lock
   a_r5_lock_set: assert property (@(posedge clk) disable iff (rst)
      (hit && !q.lock && lock_req) |=> q.lock);
   // R7: a locked group with no clear pending holds its fields
   a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
      (q.lock && clr == '0) |=> $stable(q));
   // R8: bits written with 1 read zero afterwards when no capture occurs
   a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
      !(hit && !q.lock) |=> ((q & $past(clr)) == '0));
endmodule

// File: rtl/esc_reg_map.sv
module esc_reg_map
   import esc_pkg::*;
#(
   parameter int NUM_MASTERS = 4,
   parameter int FIELD_W     = 8,
   parameter int DATA_W      = 32,
   parameter bit MASTER0_MSB = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  syn_t [NUM_MASTERS-1:0] grp,
   input  logic                   wr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output syn_t [NUM_MASTERS-1:0] clr
);
   localparam int USED_W = NUM_MASTERS * FIELD_W;

   function automatic int slot_of(input int m);
      return MASTER0_MSB ? (NUM_MASTERS - 1 - m) : m;
   endfunction

   always_comb begin
      rdata = '0;
      for (int m = 0; m < NUM_MASTERS; m++) begin
         rdata[slot_of(m)*FIELD_W +: SYN_W] = grp[m];
         clr[m] = wr ? syn_t'(wdata[slot_of(m)*FIELD_W +: SYN_W]) : '0;
      end
   end

   if (FIELD_W > SYN_W) begin : g_res_chk
      logic [DATA_W-1:0] res_mask;
      always_comb begin
         res_mask = '0;
         for (int m = 0; m < NUM_MASTERS; m++)
            res_mask[m*FIELD_W + SYN_W +: FIELD_W - SYN_W] = '1;
         if (DATA_W > USED_W)
            res_mask[DATA_W-1:USED_W] = '1;
      end
      // R11: reserved bits read zero
      a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
         (rdata & res_mask) == '0);
   end
endmodule

// File: rtl/err_syndrome_capture.sv
module err_syndrome_capture
   import esc_pkg::*;
#(
   parameter int NUM_MASTERS = 4,
   parameter int FIELD_W     = 8,
   parameter int DATA_W      = 32,
   parameter bit MASTER0_MSB = 1'b1,
   localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic [ID_W-1:0]   ev_master,
   input  logic [1:0]        ev_class,
   input  logic              ev_read,
   input  logic              ev_lock_req,
   input  logic              sw_wr,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] sw_rdata
);
   initial begin
      assert (FIELD_W >= SYN_W) else $error("FIELD_W too small for a syndrome group");
      assert (NUM_MASTERS * FIELD_W <= DATA_W) else $error("groups do not fit in DATA_W");
      assert (NUM_MASTERS >= 1) else $error("NUM_MASTERS must be positive");
   end

   logic [NUM_MASTERS-1:0] hit;
   logic [TYPE_W-1:0]      code;
   syn_t [NUM_MASTERS-1:0] grp;
   syn_t [NUM_MASTERS-1:0] clr;

   esc_evt_decode #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) u_dec (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_master(ev_master),
      .ev_class(ev_class), .hit(hit), .code(code));

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_grp
      esc_syn_group u_grp (
         .clk(clk), .rst(rst), .hit(hit[m]), .code(code), .rd_in(ev_read),
         .lock_req(ev_lock_req), .clr(clr[m]), .q(grp[m]));
   end

   esc_reg_map #(.NUM_MASTERS(NUM_MASTERS), .FIELD_W(FIELD_W), .DATA_W(DATA_W),
                 .MASTER0_MSB(MASTER0_MSB)) u_map (
      .clk(clk), .rst(rst), .grp(grp), .wr(sw_wr), .wdata(sw_wdata),
      .rdata(sw_rdata), .clr(clr));

   // R1: the word is zero in the cycle after reset
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (sw_rdata == '0));
endmodule

// File: tb/test_err_syndrome_capture.sv
module test_err_syndrome_capture;
   logic        clk = 1'b0;
   logic        rst;
   logic        ev_valid, ev_read, ev_lock_req, sw_wr;
   logic [1:0]  ev_master, ev_class;
   logic [31:0] sw_wdata, sw_rdata;

   int total = 0;
   int fails = 0;
   bit done  = 0;
   logic [4:0] mdl [4];

   always #5 clk = ~clk;

   err_syndrome_capture i_err_syndrome_capture (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_master(ev_master),
      .ev_class(ev_class), .ev_read(ev_read), .ev_lock_req(ev_lock_req),
      .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata));

   function automatic logic [31:0] expect_word();
      logic [31:0] w = '0;
      for (int m = 0; m < 4; m++) w[(3-m)*8 +: 8] = {3'b000, mdl[m]};
      return w;
   endfunction

   task automatic check(input string tag);
      total++;
      if (sw_rdata !== expect_word()) begin
         fails++;
         $display("FAIL %s: rdata=%h expected=%h", tag, sw_rdata, expect_word());
      end
   endtask

   task automatic cyc(input logic v, input logic [1:0] id, input logic [1:0] cls,
                      input logic r, input logic l, input logic w, input logic [31:0] wd);
      ev_valid = v; ev_master = id; ev_class = cls; ev_read = r; ev_lock_req = l;
      sw_wr = w; sw_wdata = wd;
      @(posedge clk);
      for (int m = 0; m < 4; m++) begin
         if (v && cls != 2'b00 && id == 2'(m) && !mdl[m][4])
            mdl[m] = {l, r, (cls == 2'b01) ? 3'b001 : 3'b101};
         else if (w)
            mdl[m] = mdl[m] & ~wd[(3-m)*8 +: 5];
      end
      @(negedge clk);
      ev_valid = 0; sw_wr = 0; sw_wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: rdata=%h expected=%h", sw_rdata, expect_word());
      finish_run();
   end

   initial begin
      rst = 1; ev_valid = 0; ev_master = 0; ev_class = 0; ev_read = 0;
      ev_lock_req = 0; sw_wr = 0; sw_wdata = '0;
      for (int m = 0; m < 4; m++) mdl[m] = '0;
      repeat (3) @(negedge clk);
      rst = 0;
      check("R1 reset");

      // Sweep: every master, class, direction and lock request (R2 R3 R4 R5 R6 R11 R12)
      for (int m = 0; m < 4; m++)
         for (int c = 1; c < 4; c++)
            for (int r = 0; r < 2; r++)
               for (int l = 0; l < 2; l++) begin
                  cyc(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
                  check("R8 clear-all");
                  cyc(1, 2'(m), 2'(c), r[0], l[0], 0, 0);
                  check(c == 1 ? "R2/R4/R5/R11/R12 parity" : "R3/R4/R5/R11/R12 abort");
               end

      // R6: unlocked capture is overwritten by a later error
      cyc(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
      cyc(1, 1, 2'b01, 0, 0, 0, 0);
      check("R6 first unlocked");
      cyc(1, 1, 2'b11, 1, 0, 0, 0);
      check("R6 overwrite");

      // R7: a locked group ignores later errors
      cyc(1, 2, 2'b01, 0, 1, 0, 0);
      check("R5 lock set");
      cyc(1, 2, 2'b10, 1, 0, 0, 0);
      check("R7 frozen lock_req low");
      cyc(1, 2, 2'b11, 1, 1, 0, 0);
      check("R7 frozen lock_req high");

      // R8: bitwise W1C; zeros leave bits alone; lock release re-arms capture
      cyc(0, 0, 0, 0, 0, 1, 32'h0000_0100);
      check("R8 clear type bit0");
      cyc(0, 0, 0, 0, 0, 1, 32'h0000_0000);
      check("R8 write zero");
      cyc(0, 0, 0, 0, 0, 1, 32'h0000_1000);
      check("R8 clear lock");
      cyc(1, 2, 2'b10, 1, 0, 0, 0);
      check("R8 capture after unlock");

      // R9: capture and clear collide on an unlocked master
      cyc(1, 3, 2'b01, 0, 0, 0, 0);
      cyc(1, 3, 2'b10, 1, 1, 1, 32'hFFFF_FFFF);
      check("R9 capture beats clear");
      // R9 counterpart: locked master, clear including lock with same-cycle error
      cyc(1, 3, 2'b01, 0, 0, 1, 32'h0000_001F);
      check("R9 locked clear applied");
      cyc(1, 3, 2'b01, 0, 0, 0, 0);
      check("R9 recapture after clear");

      // R10: strobe low or class 00 changes nothing
      cyc(1, 0, 2'b00, 1, 1, 0, 0);
      check("R10 class none");
      cyc(0, 1, 2'b11, 1, 1, 0, 0);
      check("R10 valid low");

      // R11: reserved bits ignore writes and read zero
      cyc(1, 0, 2'b11, 1, 1, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 32'hE0E0_E0E0);
      check("R11 reserved write");

      // R1 again: reset from a populated state
      rst = 1;
      @(negedge clk);
      rst = 0;
      for (int m = 0; m < 4; m++) mdl[m] = '0;
      check("R1 reset populated");

      finish_run();
   end
endmodule